// File: doc/BRIEF.md
# Vector Shape Schedule Configuration Unit

This block carries out the shape-setup instruction of a vector processor. A single 32-bit instruction word arrives with a valid strobe. The unit unpacks three dimension fields, a 4-bit remap mode and a vertical-first flag. From the mode it derives a vector length and fills four 32-bit shape-descriptor registers with per-operand templates.

In matrix mode, the length is the product of the three dimensions. In butterfly mode, the length is the number of butterfly operations of an N-point transform, that is (N/2)·log2(N). In every mode the length goes into both the maximum-length and the current-length fields of a state register, and the vertical-first bit of the machine state follows the flag in the instruction.

The surrounding core consumes the register outputs through write strobes that pulse together with a done signal, one cycle after the instruction is accepted. Any mode other than matrix or butterfly produces a length of zero and blank shape registers.

Top module: `vshape_cfg_unit`

## Requirements
- R1: The instruction word is read with bit 31 as the most significant bit. Primary opcode is insn[31:26], xd is insn[25:21], yd is insn[20:16], zd is insn[15:11], mode is insn[10:7], vf is insn[6] and the sub-opcode is insn[5:1]. The instruction executes only when the primary opcode equals PRIMARY_OP and the sub-opcode equals 5'b00001. Any other word produces no done, no strobe and no change on any register output.
- R2: One cycle after a valid executing instruction, done_o, state_we_o, shape_we_o and vf_we_o are high for exactly one cycle, and the register outputs already show the new values in that cycle.
- R3: In matrix mode (mode 4'b0000) the length is (xd+1)·(yd+1)·(zd+1), truncated to LEN_W bits.
- R4: In matrix mode, each of the four shape registers holds {1'b0,xd} in bits [31:26] and {1'b0,yd} in bits [25:20]. Shape register 2 also holds permute code 3'b001 in bits [13:11] and skip code 2'b11 in bits [3:2]. All other bits are zero.
- R5: In butterfly mode (mode 4'b0001) the length is ((xd+1)·L)/2, truncated to LEN_W bits. L is the number of consecutive 1 bits of xd counted upward from bit 0, with a limit of 5.
- R6: In butterfly mode, each of the four shape registers holds {1'b0,xd} in bits [31:26]. Shape register 1 holds schedule code 2'b01 in bits [3:2] and shape register 2 holds schedule code 2'b10 in bits [3:2]. All other bits are zero.
- R7: The state output carries the length in bits [31:25] (maximum length) and again in bits [24:18] (current length). Bits [17:0] are zero.
- R8: On every executing instruction, vf_o takes the value of insn[6].
- R9: For any mode other than 4'b0000 and 4'b0001, the state output and all four shape registers become zero.
- R10: After reset, all register outputs, strobes and done are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid_i | input | 1 | Instruction word is valid this cycle |
| insn_i | input | 32 | Instruction word |
| state_o | output | 32 | State register: maximum length and current length |
| state_we_o | output | 1 | Write strobe for state_o |
| shape0_o | output | 32 | Shape descriptor 0 |
| shape1_o | output | 32 | Shape descriptor 1 |
| shape2_o | output | 32 | Shape descriptor 2 |
| shape3_o | output | 32 | Shape descriptor 3 |
| shape_we_o | output | 1 | Write strobe for all four shape descriptors |
| vf_o | output | 1 | Vertical-first machine-state bit |
| vf_we_o | output | 1 | Write strobe for vf_o |
| done_o | output | 1 | Instruction completed |

## Verification
The bench uses the default parameters: PRIMARY_OP of 22 and a 7-bit length. With the 7-bit width, length wrap-around is easy to reach. A 6×6×4 matrix wraps 144 to 16, and a 32-point butterfly gives 80, close to the limit. The odd butterfly size xd=5 shows that only the trailing run of ones counts toward L. Words with a wrong sub-opcode or a wrong primary opcode are sent between executing words, to show that outputs hold. Undefined modes sent after filled registers show the clearing.

// File: rtl/vshape_pkg.sv
package vshape_pkg;
  localparam int WORD_W     = 32;
  localparam int OP_W       = 6;
  localparam int DIM_W      = 5;
  localparam int MODE_W     = 4;
  localparam int XO_W       = 5;
  localparam int NUM_SHAPES = 4;
  localparam int LOG_LIMIT  = 5;

  localparam logic [XO_W-1:0]   XO_SHAPE    = 5'b00001;
  localparam logic [MODE_W-1:0] MODE_MATRIX = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_BFLY   = 4'b0001;

  // shape descriptor field positions (bit 31 is the most significant)
  localparam int XDIM_HI  = 31;
  localparam int YDIM_HI  = 25;
  localparam int PERM_HI  = 13;
  localparam int SCHED_HI = 3;

  localparam logic [2:0] PERM_XZY      = 3'b001;
  localparam logic [1:0] SKIP_Y        = 2'b11;
  localparam logic [1:0] SCHED_HALFSTP = 2'b01;
  localparam logic [1:0] SCHED_COEFF   = 2'b10;

  typedef logic [WORD_W-1:0] word_t;

  // packed in the same most-significant-first order as the instruction
  typedef struct packed {
    logic [OP_W-1:0]   po;
    logic [DIM_W-1:0]  xd;
    logic [DIM_W-1:0]  yd;
    logic [DIM_W-1:0]  zd;
    logic [MODE_W-1:0] mode;
    logic              vf;
    logic [XO_W-1:0]   xo;
    logic              rsv;
  } shape_insn_t;
endpackage

// File: rtl/vshape_decode.sv
module vshape_decode
  import vshape_pkg::*;
#(
  parameter logic [OP_W-1:0] PRIMARY_OP = 6'd22
) (
  input  logic        valid_i,
  input  word_t       insn_i,
  output shape_insn_t fields_o,
  output logic        exec_o
);
  always_comb begin
    fields_o = shape_insn_t'(insn_i);
    exec_o   = valid_i && (fields_o.po == PRIMARY_OP) && (fields_o.xo == XO_SHAPE);
  end
endmodule

// File: rtl/vshape_len.sv
module vshape_len
  import vshape_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DIM_W-1:0]  xd_i,
  input  logic [DIM_W-1:0]  yd_i,
  input  logic [DIM_W-1:0]  zd_i,
  output logic [LEN_W-1:0]  len_o
);
  localparam int EXT_W  = DIM_W + 1;
  localparam int PROD_W = 3 * EXT_W;
  localparam int CNT_W  = $clog2(LOG_LIMIT + 1);
  localparam int BF_W   = EXT_W + CNT_W;
  localparam int SCAN_N = (DIM_W < LOG_LIMIT) ? DIM_W : LOG_LIMIT;

  logic [EXT_W-1:0]  xs, ys, zs;
  logic [PROD_W-1:0] prod;
  logic [CNT_W-1:0]  log_cnt;
  logic              run;
  logic [BF_W-1:0]   bfly_ops;

  always_comb begin
    xs   = {1'b0, xd_i} + EXT_W'(1);
    ys   = {1'b0, yd_i} + EXT_W'(1);
    zs   = {1'b0, zd_i} + EXT_W'(1);
    prod = PROD_W'(xs) * PROD_W'(ys) * PROD_W'(zs);
  end

  // trailing-ones scan of xd gives log2 of the transform size
  always_comb begin
    log_cnt = '0;
    run     = 1'b1;
    for (int i = 0; i < SCAN_N; i++) begin
      if (!xd_i[i]) run = 1'b0;
      if (run) log_cnt = log_cnt + CNT_W'(1);
    end
    bfly_ops = (BF_W'(xs) * BF_W'(log_cnt)) >> 1;
  end

  always_comb begin
    if (mode_i == MODE_MATRIX)    len_o = prod[LEN_W-1:0];
    else if (mode_i == MODE_BFLY) len_o = LEN_W'(bfly_ops);
    else                          len_o = '0;
  end
endmodule

// File: rtl/vshape_tmpl.sv
module vshape_tmpl
  import vshape_pkg::*;
(
  input  logic [MODE_W-1:0]                  mode_i,
  input  logic [DIM_W-1:0]                   xd_i,
  input  logic [DIM_W-1:0]                   yd_i,
  output logic [NUM_SHAPES-1:0][WORD_W-1:0]  shapes_o
);
  logic is_mat, is_bfly;
  always_comb begin
    is_mat  = (mode_i == MODE_MATRIX);
    is_bfly = (mode_i == MODE_BFLY);
  end

  for (genvar g = 0; g < NUM_SHAPES; g++) begin : g_shape
    always_comb begin
      shapes_o[g] = '0;
      if (is_mat || is_bfly)
        shapes_o[g][XDIM_HI -: DIM_W+1] = {1'b0, xd_i};
      if (is_mat)
        shapes_o[g][YDIM_HI -: DIM_W+1] = {1'b0, yd_i};
      if (g == 2 && is_mat) begin
        shapes_o[g][PERM_HI -: 3]  = PERM_XZY;
        shapes_o[g][SCHED_HI -: 2] = SKIP_Y;
      end
      if (g == 1 && is_bfly) shapes_o[g][SCHED_HI -: 2] = SCHED_HALFSTP;
      if (g == 2 && is_bfly) shapes_o[g][SCHED_HI -: 2] = SCHED_COEFF;
    end
  end
endmodule

// File: rtl/vshape_cfg_unit.sv
module vshape_cfg_unit
  import vshape_pkg::*;
#(
  parameter logic [5:0] PRIMARY_OP = 6'd22,
  parameter int         LEN_W      = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid_i,
  input  logic [31:0] insn_i,
  output logic [31:0] state_o,
  output logic        state_we_o,
  output logic [31:0] shape0_o,
  output logic [31:0] shape1_o,
  output logic [31:0] shape2_o,
  output logic [31:0] shape3_o,
  output logic        shape_we_o,
  output logic        vf_o,
  output logic        vf_we_o,
  output logic        done_o
);
  localparam int STATE_PAD = WORD_W - 2 * LEN_W;
  localparam int MVL_HI    = WORD_W - 1;
  localparam int VL_HI     = WORD_W - 1 - LEN_W;

  shape_insn_t f;
  logic        exec;
  logic [LEN_W-1:0] len;
  logic [NUM_SHAPES-1:0][WORD_W-1:0] shapes_n;

  vshape_decode #(.PRIMARY_OP(PRIMARY_OP)) i_decode (
    .valid_i(insn_valid_i), .insn_i(insn_i), .fields_o(f), .exec_o(exec)
  );

  vshape_len #(.LEN_W(LEN_W)) i_len (
    .mode_i(f.mode), .xd_i(f.xd), .yd_i(f.yd), .zd_i(f.zd), .len_o(len)
  );

  vshape_tmpl i_tmpl (
    .mode_i(f.mode), .xd_i(f.xd), .yd_i(f.yd), .shapes_o(shapes_n)
  );

  logic [WORD_W-1:0] state_q, state_d;
  logic [NUM_SHAPES-1:0][WORD_W-1:0] shape_q, shape_d;
  logic vf_q, vf_d, done_q, done_d;

  always_comb begin
    state_d = state_q;
    shape_d = shape_q;
    vf_d    = vf_q;
    done_d  = exec;
    if (exec) begin
      state_d = {len, len, {STATE_PAD{1'b0}}};
      shape_d = shapes_n;
      vf_d    = f.vf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      shape_q <= '0;
      vf_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (exec) begin
        state_q <= state_d;
        shape_q <= shape_d;
        vf_q    <= vf_d;
      end
    end
  end

  assign state_o    = state_q;
  assign shape0_o   = shape_q[0];
  assign shape1_o   = shape_q[1];
  assign shape2_o   = shape_q[2];
  assign shape3_o   = shape_q[3];
  assign vf_o       = vf_q;
  assign done_o     = done_q;
  assign state_we_o = done_q;
  assign shape_we_o = done_q;
  assign vf_we_o    = done_q;

  assert_done_after_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid_i && insn_i[31:26] == PRIMARY_OP && insn_i[5:1] == XO_SHAPE) |=> done_o);

  assert_ignored_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(insn_valid_i && insn_i[31:26] == PRIMARY_OP && insn_i[5:1] == XO_SHAPE)
      |=> (!done_o && $stable(state_o) && $stable(shape0_o) && $stable(shape2_o) && $stable(vf_o)));

  assert_lengths_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (state_o[MVL_HI -: LEN_W] == state_o[VL_HI -: LEN_W]));

  assert_undef_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && insn_i[10:7] != MODE_MATRIX && insn_i[10:7] != MODE_BFLY)
      |=> (state_o == '0 && shape0_o == '0 && shape1_o == '0 && shape2_o == '0 && shape3_o == '0));

  assert_coeff_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && insn_i[10:7] == MODE_BFLY) |=> (shape2_o[SCHED_HI -: 2] == SCHED_COEFF));

  assert_vf_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> (vf_o == $past(insn_i[6])));
endmodule

// File: tb/test_vshape_cfg_unit.sv
`timescale 1ns/1ps
module test_vshape_cfg_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] state, sh0, sh1, sh2, sh3;
  logic state_we, shape_we, vf, vf_we, done;

  always #2.5 clk = ~clk;

  vshape_cfg_unit i_vshape_cfg_unit (
    .clk(clk), .rst_n(rst_n), .insn_valid_i(insn_valid), .insn_i(insn),
    .state_o(state), .state_we_o(state_we),
    .shape0_o(sh0), .shape1_o(sh1), .shape2_o(sh2), .shape3_o(sh3),
    .shape_we_o(shape_we), .vf_o(vf), .vf_we_o(vf_we), .done_o(done)
  );

  typedef struct {
    logic [31:0] st;
    logic [31:0] s0, s1, s2, s3;
    logic        vfb;
    int          mode;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int failures = 0;
  logic [31:0] last_state;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(int po, int xd, int yd, int zd, int mode, int vfb, int xo);
    return {6'(po), 5'(xd), 5'(yd), 5'(zd), 4'(mode), 1'(vfb), 5'(xo), 1'b0};
  endfunction

  function automatic exp_t model(int xd, int yd, int zd, int mode, int vfb);
    exp_t e;
    int len, l;
    logic [31:0] t;
    e.vfb = 1'(vfb); e.mode = mode;
    e.s0 = '0; e.s1 = '0; e.s2 = '0; e.s3 = '0; len = 0;
    if (mode == 0) begin
      len = ((xd + 1) * (yd + 1) * (zd + 1)) % 128;
      t = '0; t[31:26] = 6'(xd); t[25:20] = 6'(yd);
      e.s0 = t; e.s1 = t; e.s3 = t;
      e.s2 = t; e.s2[13:11] = 3'b001; e.s2[3:2] = 2'b11;
    end else if (mode == 1) begin
      l = 0;
      while (l < 5 && ((xd >> l) & 1) == 1) l++;
      len = (((xd + 1) * l) / 2) % 128;
      t = '0; t[31:26] = 6'(xd);
      e.s0 = t; e.s3 = t;
      e.s1 = t; e.s1[3:2] = 2'b01;
      e.s2 = t; e.s2[3:2] = 2'b10;
    end
    e.st = {7'(len), 7'(len), 18'b0};
    return e;
  endfunction

  // driver: push expectation, present word for one cycle, confirm the pulse ends
  task automatic issue(int xd, int yd, int zd, int mode, int vfb);
    sb.push_back(model(xd, yd, zd, mode, vfb));
    @(negedge clk);
    insn = enc(22, xd, yd, zd, mode, vfb, 1);
    insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R2 done width", {31'b0, done}, 32'h0);
  endtask

  task automatic issue_bad(int po, int xo);
    @(negedge clk);
    insn = enc(po, 3, 3, 3, 0, 1, xo);
    insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(state == last_state, "R1 ignored word", state, last_state);
  endtask

  // monitor: compare on every done
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R1 unexpected done", 32'h1, 32'h0);
      end else begin
        exp_t e;
        string vt, st;
        e = sb.pop_front();
        vt = (e.mode == 0) ? "R3/R7 matrix length" : (e.mode == 1) ? "R5/R7 butterfly length" : "R9 undefined state";
        st = (e.mode == 0) ? "R4 matrix shape" : (e.mode == 1) ? "R6 butterfly shape" : "R9 undefined shape";
        check(state == e.st, vt, state, e.st);
        check(sh0 == e.s0, st, sh0, e.s0);
        check(sh1 == e.s1, st, sh1, e.s1);
        check(sh2 == e.s2, st, sh2, e.s2);
        check(sh3 == e.s3, st, sh3, e.s3);
        check(vf == e.vfb, "R8 vertical-first", {31'b0, vf}, {31'b0, e.vfb});
        check(state_we && shape_we && vf_we, "R2 strobes", {29'b0, state_we, shape_we, vf_we}, 32'h7);
        last_state = e.st;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    last_state = '0;
    repeat (3) @(negedge clk);
    check(state == 0 && sh0 == 0 && sh1 == 0 && sh2 == 0 && sh3 == 0 && !vf && !done && !state_we,
          "R10 reset", state, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(1, 1, 2, 0, 0);   // 2x2x3 -> 12
    issue(3, 2, 2, 0, 1);   // 4x3x3 -> 36
    issue_bad(22, 2);       // wrong sub-opcode
    issue(4, 4, 4, 0, 0);   // 125
    issue(5, 5, 3, 0, 1);   // 144 wraps to 16
    issue(1, 0, 0, 1, 1);   // N=2 -> 1
    issue(3, 0, 0, 1, 0);   // N=4 -> 4
    issue_bad(21, 1);       // wrong primary opcode
    issue(7, 0, 0, 1, 1);   // N=8 -> 12
    issue(15, 0, 0, 1, 0);  // N=16 -> 32
    issue(31, 0, 0, 1, 1);  // N=32 -> 80
    issue(5, 0, 0, 1, 0);   // trailing run of one -> 3
    issue(2, 3, 4, 7, 1);   // undefined mode clears
    issue(6, 1, 1, 0, 0);
    issue(2, 3, 4, 15, 0);  // undefined mode clears again
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2 all results seen", 32'(sb.size()), 32'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule